// File: doc/BRIEF.md
# Serial Flash Deep Sleep and Identity Controller

This block is the device-side command front end of a serial flash that governs the low-power sleep state. A host selects the device by pulling the active-low select low. It then clocks an 8-bit opcode in, most significant bit first, on rising serial clock edges. The block oversamples the select, serial clock and data lines with a free-running system clock. It counts the bits of each selection and acts when the select is released.

The sleep opcode starts a timed entry into the power-down state. The entry happens only when the select is released right after the eighth bit and no program or erase cycle is running. While the device is asleep it ignores every opcode except the wake/identify opcode. That opcode starts a timed exit back to standby. Issued from standby and followed by three dummy bytes, the same opcode returns a one-byte device identifier on the serial output. The identifier changes on falling serial clock edges and repeats for as long as the host keeps clocking.

Top module: `flash_pd_ctrl`

## Requirements
- R1: After reset the block is in standby: `ready_o`=1, `pd_o`=0, `do_oe_o`=0.
- R2: A selection started in standby that carries opcode 8'hB9 and is released after exactly 8 bits, with `busy_i` low, drops `ready_o`. `pd_o` then rises exactly T_DP system clocks after `ready_o` fell.
- R3: Opcode 8'hB9 has no effect when the select is released after any bit count other than 8 (for example 7, 9 or 16).
- R4: A sleep request that arrives while `busy_i` is high is rejected: the state stays standby.
- R5: While asleep, every opcode other than 8'hAB is ignored: `pd_o` stays 1 and `do_oe_o` stays 0.
- R6: Opcode 8'hAB with at least 8 bits, in a selection started while asleep, drops `pd_o` at select release. `ready_o` rises exactly T_RES system clocks later.
- R7: Opcode 8'hAB started in standby, followed by 24 dummy bits, makes the block drive DEV_ID on `do_o`, MSB first. A new bit is launched on each falling serial clock edge, starting with the edge after the 32nd rising edge, and the byte repeats after 8 bits.
- R8: `do_oe_o` is low whenever the select is high, and during the opcode and dummy bits.
- R9: Selecting and deselecting with no bits, or with any opcode other than 8'hB9 or 8'hAB, leaves the block in standby.
- R10: A selection that starts during the entry or exit delay is ignored: it produces no identifier output and no state change.
- R11: Bit count and opcode clear on every deselect, so a sleep opcode split over two selections (4 bits plus 4 bits) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low device select |
| di_i | input | 1 | Serial data in |
| busy_i | input | 1 | Program/erase/write cycle in progress |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for `do_o` |
| pd_o | output | 1 | Device is in deep sleep |
| ready_o | output | 1 | Standby, normal commands accepted |

## Verification
If the bit counter holds a wrong value, a sleep command sent at a legal byte boundary is missed, or one sent off a boundary is accepted. Either shows on `ready_o` within a few system clocks of select release. A stuck power state shows as `pd_o` or `ready_o` edges whose distance differs from T_DP or T_RES; the bench counts that distance exactly. A wrong output index shows as a wrong or shifted identifier bit at the first host sample after the 32nd clock. It also shows when the byte fails to repeat.

// File: rtl/flash_pd_pkg.sv
package flash_pd_pkg;
  typedef enum logic [1:0] {
    PWR_STANDBY = 2'd0,
    PWR_ENTER   = 2'd1,
    PWR_DOWN    = 2'd2,
    PWR_WAKE    = 2'd3
  } pwr_state_e;

  localparam int unsigned OP_W      = 8;
  localparam int unsigned DUMMY_W   = 24;
  localparam logic [OP_W-1:0] OP_SLEEP   = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE_ID = 8'hAB;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic di_i,
  output logic sel_o,
  output logic sel_start_o,
  output logic sel_end_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic di_o
);
  localparam int unsigned W = 3;
  localparam logic [W-1:0] RST_VAL = 3'b010; // {sclk, cs_n, di}

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0] settled;
  logic         sclk_prev_q, sel_prev_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {sclk_i, cs_ni, di_i};
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], {sclk_i, cs_ni, di_i}};
  end

  assign settled = stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= settled[2];
      sel_prev_q  <= ~settled[1];
    end
  end

  assign sel_o       = ~settled[1];
  assign di_o        = settled[0];
  assign sclk_rise_o = sel_o & settled[2] & ~sclk_prev_q;
  assign sclk_fall_o = sel_o & ~settled[2] & sclk_prev_q;
  assign sel_start_o = sel_o & ~sel_prev_q;
  assign sel_end_o   = ~sel_o & sel_prev_q;
endmodule

// File: rtl/fpd_cmd_rx.sv
module fpd_cmd_rx
  import flash_pd_pkg::*;
#(
  parameter int unsigned OPW = OP_W,
  parameter int unsigned PRE = OP_W + DUMMY_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            sel_start_i,
  input  logic            sclk_rise_i,
  input  logic            di_i,
  input  pwr_state_e      state_i,
  output logic [OPW-1:0]  opcode_o,
  output logic            op_valid_o,
  output logic            exact_byte_o,
  output logic            preamble_done_o,
  output pwr_state_e      start_state_o
);
  localparam int unsigned CNT_W = $clog2(PRE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OPW-1:0]   shreg_q, opcode_q;
  pwr_state_e       start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shreg_q  <= '0;
      opcode_q <= '0;
    end else if (!sel_i) begin
      cnt_q    <= '0;
      shreg_q  <= '0;
      opcode_q <= '0;
    end else if (sclk_rise_i) begin
      shreg_q <= {shreg_q[OPW-2:0], di_i};
      if (cnt_q != CNT_W'(PRE)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(OPW - 1)) opcode_q <= {shreg_q[OPW-2:0], di_i};
    end
  end

  // power state seen when the selection begins decides what the selection may do
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          start_q <= PWR_STANDBY;
    else if (sel_start_i) start_q <= state_i;
  end

  assign opcode_o        = opcode_q;
  assign op_valid_o      = cnt_q >= CNT_W'(OPW);
  assign exact_byte_o    = cnt_q == CNT_W'(OPW);
  assign preamble_done_o = cnt_q == CNT_W'(PRE);
  assign start_state_o   = start_q;

  AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/fpd_pwr_ctl.sv
module fpd_pwr_ctl
  import flash_pd_pkg::*;
#(
  parameter int unsigned T_DP  = 20,
  parameter int unsigned T_RES = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       busy_i,
  output pwr_state_e state_o,
  output logic       pd_o,
  output logic       ready_o
);
  localparam int unsigned T_MAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int unsigned TMR_W = $clog2(T_MAX + 1);

  pwr_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = '0;
    unique case (state_q)
      PWR_STANDBY: if (sleep_req_i && !busy_i) state_d = PWR_ENTER;
      PWR_ENTER: begin
        if (tmr_q == TMR_W'(T_DP - 1)) state_d = PWR_DOWN;
        else                           tmr_d   = tmr_q + 1'b1;
      end
      PWR_DOWN: if (wake_req_i) state_d = PWR_WAKE;
      PWR_WAKE: begin
        if (tmr_q == TMR_W'(T_RES - 1)) state_d = PWR_STANDBY;
        else                            tmr_d   = tmr_q + 1'b1;
      end
      default: state_d = PWR_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_STANDBY;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;
  assign pd_o    = state_q == PWR_DOWN;
  assign ready_o = state_q == PWR_STANDBY;

  AST_SLEEP_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_STANDBY && busy_i) |=> (state_q == PWR_STANDBY)); // R4
  AST_DOWN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_DOWN && !wake_req_i) |=> (state_q == PWR_DOWN)); // R5
  AST_WAKE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_WAKE) |-> (tmr_q < TMR_W'(T_RES))); // R6
endmodule

// File: rtl/fpd_id_tx.sv
module fpd_id_tx #(
  parameter int unsigned        ID_W   = 8,
  parameter logic [ID_W-1:0]    DEV_ID = 8'h5C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sclk_fall_i,
  input  logic enable_i,
  output logic do_o,
  output logic oe_o
);
  localparam int unsigned IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

  logic [IDX_W-1:0] idx_q;
  logic             do_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_W'(ID_W - 1);
      do_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!sel_i) begin
      idx_q <= IDX_W'(ID_W - 1);
      do_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (sclk_fall_i && enable_i) begin
      oe_q  <= 1'b1;
      do_q  <= DEV_ID[idx_q];
      idx_q <= (idx_q == '0) ? IDX_W'(ID_W - 1) : idx_q - 1'b1; // wrap repeats the byte
    end
  end

  assign do_o = do_q;
  assign oe_o = oe_q;

  AST_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !oe_q); // R8
endmodule

// File: rtl/flash_pd_ctrl.sv
module flash_pd_ctrl
  import flash_pd_pkg::*;
#(
  parameter int unsigned     T_DP        = 20,
  parameter int unsigned     T_RES       = 30,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [7:0]      DEV_ID      = 8'h5C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic di_i,
  input  logic busy_i,
  output logic do_o,
  output logic do_oe_o,
  output logic pd_o,
  output logic ready_o
);
  logic            sel, sel_start, sel_end, sclk_rise, sclk_fall, di_s;
  logic [OP_W-1:0] opcode;
  logic            op_valid, exact_byte, preamble_done;
  pwr_state_e      state, start_state;
  logic            sleep_req, wake_req, id_en;

  fpd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .di_i,
    .sel_o(sel), .sel_start_o(sel_start), .sel_end_o(sel_end),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .di_o(di_s)
  );

  fpd_cmd_rx #(.OPW(OP_W), .PRE(OP_W + DUMMY_W)) i_cmd_rx (
    .clk_i, .rst_ni,
    .sel_i(sel), .sel_start_i(sel_start), .sclk_rise_i(sclk_rise), .di_i(di_s),
    .state_i(state),
    .opcode_o(opcode), .op_valid_o(op_valid), .exact_byte_o(exact_byte),
    .preamble_done_o(preamble_done), .start_state_o(start_state)
  );

  // sleep needs release exactly at the byte boundary; wake needs any complete opcode
  assign sleep_req = sel_end && start_state == PWR_STANDBY && exact_byte && opcode == OP_SLEEP;
  assign wake_req  = sel_end && start_state == PWR_DOWN && op_valid && opcode == OP_WAKE_ID;
  assign id_en     = start_state == PWR_STANDBY && preamble_done && opcode == OP_WAKE_ID;

  fpd_pwr_ctl #(.T_DP(T_DP), .T_RES(T_RES)) i_pwr_ctl (
    .clk_i, .rst_ni,
    .sleep_req_i(sleep_req), .wake_req_i(wake_req), .busy_i,
    .state_o(state), .pd_o, .ready_o
  );

  fpd_id_tx #(.ID_W(8), .DEV_ID(DEV_ID)) i_id_tx (
    .clk_i, .rst_ni,
    .sel_i(sel), .sclk_fall_i(sclk_fall), .enable_i(id_en),
    .do_o, .oe_o(do_oe_o)
  );

  AST_NO_DO_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !do_oe_o); // R5
  AST_READY_XOR_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && pd_o)); // R2
endmodule

// File: tb/test_flash_pd_ctrl.sv
module test_flash_pd_ctrl;
  localparam int unsigned T_DP  = 20;
  localparam int unsigned T_RES = 30;
  localparam int unsigned HALF  = 8;
  localparam logic [7:0]  DEV_ID = 8'h5C;

  typedef struct {bit oe; bit d; string req;} exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, di = 1'b0, busy = 1'b0;
  logic do_w, oe_w, pd, rdy;
  int   errors = 0, checks = 0;
  exp_t exp_q[$];
  event smp;

  always #5 clk = ~clk;

  flash_pd_ctrl #(.T_DP(T_DP), .T_RES(T_RES), .SYNC_STAGES(2), .DEV_ID(DEV_ID)) i_flash_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .di_i(di), .busy_i(busy),
    .do_o(do_w), .do_oe_o(oe_w), .pd_o(pd), .ready_o(rdy)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, input bit sample);
    di = b;
    idle(HALF);
    if (sample) ->smp;
    sclk = 1'b1;
    idle(HALF);
    sclk = 1'b0;
  endtask

  task automatic select();
    @(negedge clk); cs_n = 1'b0; idle(HALF);
  endtask

  task automatic deselect();
    idle(HALF); cs_n = 1'b1;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i], 1'b0);
  endtask

  // driver: pushes the expected output items, the monitor compares at each host sample
  task automatic read_id(input logic [7:0] op, input int nout, input bit expect_out, input string req);
    select();
    send_bits(16'(op), 8);
    check(oe_w == 1'b0, "R8", "oe during opcode", int'(oe_w), 0);
    send_bits(16'h0, 16);
    send_bits(16'h0, 8);
    for (int i = 0; i < nout; i++) begin
      exp_t e;
      e.oe  = expect_out;
      e.d   = expect_out ? DEV_ID[7 - (i % 8)] : 1'b0;
      e.req = req;
      exp_q.push_back(e);
      clk_bit(1'b0, 1'b1);
    end
    deselect();
    idle(6);
    check(oe_w == 1'b0, "R8", "oe after deselect", int'(oe_w), 0);
  endtask

  always @(smp) begin
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL monitor: unexpected sample actual=%0d expected=none", int'(do_w));
    end else begin
      e = exp_q.pop_front();
      if (oe_w !== e.oe || (e.oe && do_w !== e.d)) begin
        errors++;
        $display("FAIL %s do/oe: actual=%0d/%0d expected=%0d/%0d", e.req, int'(do_w), int'(oe_w), int'(e.d), int'(e.oe));
      end
    end
  end

  task automatic expect_state(input string req, input bit exp_rdy, input bit exp_pd);
    check(rdy == exp_rdy, req, "ready_o", int'(rdy), int'(exp_rdy));
    check(pd == exp_pd, req, "pd_o", int'(pd), int'(exp_pd));
  endtask

  task automatic sleep_measured(input string req);
    int n;
    select(); send_bits(16'hB9, 8); deselect();
    n = 0;
    while (rdy && n < 50) begin @(negedge clk); n++; end
    check(!rdy, req, "ready_o falls", int'(rdy), 0);
    n = 0;
    while (!pd && n < 500) begin @(negedge clk); n++; end
    check(n == int'(T_DP), req, "sleep delay cycles", n, int'(T_DP));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    // R1 reset state
    expect_state("R1", 1'b1, 1'b0);
    check(oe_w == 1'b0, "R1", "oe at reset", int'(oe_w), 0);
    rst_n = 1'b1;
    idle(4);
    expect_state("R1", 1'b1, 1'b0);

    // R9 empty selection and foreign opcode
    select(); deselect(); idle(40);
    expect_state("R9", 1'b1, 1'b0);
    select(); send_bits(16'h03, 8); deselect(); idle(40);
    expect_state("R9", 1'b1, 1'b0);

    // R7 identifier read with wrap after 8 bits
    read_id(8'hAB, 16, 1'b1, "R7");
    check(exp_q.size() == 0, "R7", "items left", exp_q.size(), 0);

    // R3 release away from the byte boundary
    select(); send_bits(16'h5C, 7); deselect(); idle(40);
    expect_state("R3", 1'b1, 1'b0);
    select(); send_bits(16'h172, 9); deselect(); idle(40);
    expect_state("R3", 1'b1, 1'b0);
    select(); send_bits(16'hB900, 16); deselect(); idle(40);
    expect_state("R3", 1'b1, 1'b0);

    // R11 opcode split over two selections
    select(); send_bits(16'hB, 4); deselect(); idle(4);
    select(); send_bits(16'h9, 4); deselect(); idle(40);
    expect_state("R11", 1'b1, 1'b0);

    // R4 rejected while busy
    busy = 1'b1;
    select(); send_bits(16'hB9, 8); deselect(); idle(40);
    expect_state("R4", 1'b1, 1'b0);
    busy = 1'b0;
    idle(4);

    // R2 timed entry
    sleep_measured("R2");
    expect_state("R2", 1'b0, 1'b1);

    // R5 foreign opcodes while asleep
    select(); send_bits(16'h02, 8); deselect(); idle(40);
    expect_state("R5", 1'b0, 1'b1);
    select(); send_bits(16'hB9, 8); deselect(); idle(40);
    expect_state("R5", 1'b0, 1'b1);
    read_id(8'h9F, 8, 1'b0, "R5");
    expect_state("R5", 1'b0, 1'b1);

    // R6 timed exit
    select(); send_bits(16'hAB, 8); deselect();
    n = 0;
    while (pd && n < 50) begin @(negedge clk); n++; end
    check(!pd, "R6", "pd_o falls", int'(pd), 0);
    n = 0;
    while (!rdy && n < 500) begin @(negedge clk); n++; end
    check(n == int'(T_RES), "R6", "wake delay cycles", n, int'(T_RES));
    expect_state("R6", 1'b1, 1'b0);

    // R10 selection begun during the exit delay is ignored
    sleep_measured("R2");
    select(); send_bits(16'hAB, 8); deselect();
    idle(8);
    check(!rdy && !pd, "R10", "in exit delay", int'(rdy), 0);
    read_id(8'hAB, 8, 1'b0, "R10");
    idle(40);
    expect_state("R10", 1'b1, 1'b0);
    read_id(8'hAB, 8, 1'b1, "R7");
    expect_state("R9", 1'b1, 1'b0);

    check(exp_q.size() == 0, "R7", "items left", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule